// File: doc/BRIEF.md
# Half-Bridge Command Conditioner

This block sits between a PWM source and the two switch drivers of a half-bridge. It takes the high-switch and low-switch commands as logic levels and turns them into the enables that drive the high-side level shifter and the low-side output path. Three steps happen in order. A per-input pulse filter discards any command level that does not persist for a minimum number of clock samples. A cross-check keeps both enables off whenever both filtered commands ask for drive at once. A shared gap counter stops either enable from turning on until the other enable has been off for a fixed dead time.

The filter confirms both rising and falling command edges only after the new level has held for the full minimum width. Every enable edge therefore lags its command by that width plus the output register. Turning an enable off is never delayed by the dead-time logic. Only turning an enable on waits. The minimum width is chosen from two preset values by one parameter: 3 clock samples for the short variant and 4 for the long one. At a 100 MHz clock these give 30 ns and 40 ns. The default dead time is 15 cycles.

Top module: `gdc_input_cond`

## Requirements
- R1: A level on either command input that is held for fewer than W consecutive clock samples never appears on any enable. W is the minimum width.
- R2: When the enable is otherwise free to turn on, a command held for P ≥ W samples has this effect. If the command is first sampled at edge n, its enable rises at edge n+W and stays high for exactly P cycles.
- R3: W is 3 when `LONG_FILT` is 0 and 4 when `LONG_FILT` is 1.
- R4: While both filtered commands are high, both enables are low. When the overlap ends, the surviving side turns on only after a full dead time has passed.
- R5: `ho_en` and `lo_en` are never high in the same cycle.
- R6: High to low handover. A command swap sampled from edge n is handled as follows. `ho_en` falls at edge n+W. `lo_en` rises exactly `DEAD_CYC` cycles later, so both enables are low for exactly `DEAD_CYC` cycles.
- R7: Low to high handover follows the same rule as R6 with the roles of the two sides exchanged.
- R8: Suppose the new command arrives G cycles after the old one is dropped. Both enables are then low for max(`DEAD_CYC`, G) cycles, so no extra wait is added beyond the dead time.
- R9: If the off side's command is asserted again while the other side is counting its dead time, the count is abandoned and both enables stay low. Once that command is dropped again, a complete new dead time starts.
- R10: Synchronous active-low reset drives both enables to 0 and clears the gap counter. A command already high when reset is released therefore turns its enable on at the `DEAD_CYC`-th edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | 1 | Command for the high switch |
| li_cmd | input | 1 | Command for the low switch |
| ho_en | output | 1 | Conditioned high-side enable (to level shifter) |
| lo_en | output | 1 | Conditioned low-side enable |

## Verification
The hardest case to reach is the abandoned dead time. It needs the off side's command to come back and be confirmed by its filter after the other side's count has started, but before that count has finished. The bench drops the high command and raises the low command together. It then re-raises the high command for a filter-passing width after a delay M, and sweeps M so that the overlap lands at different points of the count. The bench also sweeps the handover gap across the dead time and sweeps overlap and pulse widths across the filter threshold, running both filter variants side by side.

// File: rtl/gdc_pkg.sv
// Shared types for the command conditioner.
// Assumes: channel 0 carries the high-switch command, channel 1 the low one.
package gdc_pkg;

    localparam int unsigned CH_HIGH = 0;
    localparam int unsigned CH_LOW  = 1;
    localparam int unsigned N_CH    = 2;

    // Which side the filtered commands request
    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_HIGH  = 2'b01,
        REQ_LOW   = 2'b10,
        REQ_CLASH = 2'b11
    } req_e;

    // Map the two filtered command levels onto a request code
    function automatic req_e classify(input logic hi, input logic lo);
        return req_e'({lo, hi});
    endfunction

endpackage

// File: rtl/gdc_pulse_filter.sv
// Minimum-width filter for one command line.
// Accepts a new input level only after it has been sampled MIN_W times
// in a row. Both edges are delayed alike, so a passed pulse keeps its width.
// Assumes: the input is already synchronous to clk; MIN_W >= 1.
module gdc_pulse_filter #(
    parameter int unsigned MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW      = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(MIN_W - 1);

    logic [CW-1:0] run;

    // Count consecutive samples that disagree with the accepted level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b0;
            run   <= '0;
        end else if (raw == clean) begin
            run <= '0;
        end else if (run == RUN_LAST) begin
            clean <= raw;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/gdc_deadtime.sv
// Interlock and dead-time stage.
// Turns an enable off on the cycle after its filtered command drops or
// clashes with the other command. Turns an enable on only once both
// enables have been low for DT cycles with no clash in between.
// Assumes: DT >= 2; the inputs come from the pulse filters.
module gdc_deadtime
    import gdc_pkg::*;
#(
    parameter int unsigned DT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_f,
    input  logic lo_f,
    output logic ho_en,
    output logic lo_en
);
    localparam int unsigned CW = $clog2(DT);
    localparam logic [CW-1:0] GAP_DONE = CW'(DT - 1);

    req_e          req;
    logic [CW-1:0] gap;
    logic [CW-1:0] gap_n;
    logic          gap_full;
    logic          ho_n;
    logic          lo_n;

    assign req      = classify(hi_f, lo_f);
    assign gap_full = (gap == GAP_DONE);

    // Next enables: hold if on, start only after a full gap, clash forces off
    always_comb begin
        ho_n = 1'b0;
        lo_n = 1'b0;
        unique case (req)
            REQ_HIGH: ho_n = ho_en | (~lo_en & gap_full);
            REQ_LOW:  lo_n = lo_en | (~ho_en & gap_full);
            default: begin
                ho_n = 1'b0;
                lo_n = 1'b0;
            end
        endcase
    end

    // Gap counter: counts both-off cycles, restarts on any drive or clash
    always_comb begin
        if (ho_en || lo_en || (req == REQ_CLASH)) begin
            gap_n = '0;
        end else if (!gap_full) begin
            gap_n = gap + 1'b1;
        end else begin
            gap_n = gap;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ho_en <= 1'b0;
            lo_en <= 1'b0;
            gap   <= '0;
        end else begin
            ho_en <= ho_n;
            lo_en <= lo_n;
            gap   <= gap_n;
        end
    end

endmodule

// File: rtl/gdc_input_cond.sv
// Half-bridge command conditioner, top level.
// Filters both commands, then applies the interlock and the dead time.
// Assumes: commands are synchronous to clk; DEAD_CYC >= 2.
module gdc_input_cond
    import gdc_pkg::*;
#(
    parameter bit          LONG_FILT = 1'b0,
    parameter int unsigned SHORT_W   = 3,
    parameter int unsigned LONG_W    = 4,
    parameter int unsigned DEAD_CYC  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic li_cmd,
    output logic ho_en,
    output logic lo_en
);
    localparam int unsigned FILT_W = LONG_FILT ? LONG_W : SHORT_W;

    logic [N_CH-1:0] cmd_raw;
    logic [N_CH-1:0] cmd_clean;

    assign cmd_raw[CH_HIGH] = hi_cmd;
    assign cmd_raw[CH_LOW]  = li_cmd;

    // One filter per command channel
    for (genvar c = 0; c < N_CH; c++) begin : g_filt
        gdc_pulse_filter #(
            .MIN_W(FILT_W)
        ) i_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (cmd_raw[c]),
            .clean(cmd_clean[c])
        );
    end

    gdc_deadtime #(
        .DT(DEAD_CYC)
    ) i_dead (
        .clk  (clk),
        .rst_n(rst_n),
        .hi_f (cmd_clean[CH_HIGH]),
        .lo_f (cmd_clean[CH_LOW]),
        .ho_en(ho_en),
        .lo_en(lo_en)
    );

endmodule

// File: rtl/gdc_input_cond_chk.sv
// Property checker for the command conditioner, bound to the top level.
// Tracks how long each enable has been off with its own saturating counter.
module gdc_input_cond_chk #(
    parameter int unsigned DT = 15
) (
    input logic clk,
    input logic rst_n,
    input logic hi_clean,
    input logic lo_clean,
    input logic ho_en,
    input logic lo_en
);
    localparam int unsigned SW = $clog2(DT + 1);
    localparam logic [SW-1:0] OFF_FULL = SW'(DT);

    logic [SW-1:0] ho_off;
    logic [SW-1:0] lo_off;

    // Saturating off-time counters for both enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ho_off <= '0;
            lo_off <= '0;
        end else begin
            if (ho_en) ho_off <= '0;
            else if (ho_off != OFF_FULL) ho_off <= ho_off + 1'b1;
            if (lo_en) lo_off <= '0;
            else if (lo_off != OFF_FULL) lo_off <= lo_off + 1'b1;
        end
    end

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(ho_en && lo_en)); // R5

    AST_CLASH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_clean && lo_clean) |=> (!ho_en && !lo_en)); // R4

    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> (ho_off == OFF_FULL)); // R6

    AST_HO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho_en) |-> (lo_off == OFF_FULL)); // R7

    AST_HO_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (ho_en && !hi_clean) |=> !ho_en); // R6

    AST_LO_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en && !lo_clean) |=> !lo_en); // R7

endmodule

bind gdc_input_cond gdc_input_cond_chk #(
    .DT(DEAD_CYC)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_clean(cmd_clean[0]),
    .lo_clean(cmd_clean[1]),
    .ho_en   (ho_en),
    .lo_en   (lo_en)
);

// File: tb/test_gdc_input_cond.sv
// Bench: runs the short- and long-filter variants on shared stimulus.
module test_gdc_input_cond;
    localparam int CLK_PERIOD = 10;
    localparam int DT         = 15;
    localparam int WIN        = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi = 1'b0;
    logic       li = 1'b0;
    logic [1:0] ho;
    logic [1:0] lo;

    int errors = 0;
    int checks = 0;
    int j;
    int n_ho[2], n_lo[2], first_ho[2], first_lo[2], last_ho[2], last_lo[2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gdc_input_cond #(.LONG_FILT(1'b0), .DEAD_CYC(DT)) i_gdc_input_cond (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi), .li_cmd(li),
        .ho_en(ho[0]), .lo_en(lo[0]));

    gdc_input_cond #(.LONG_FILT(1'b1), .DEAD_CYC(DT)) i_gdc_input_cond_long (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi), .li_cmd(li),
        .ho_en(ho[1]), .lo_en(lo[1]));

    function automatic int wid(input int d);
        return (d == 0) ? 3 : 4; // R3
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string tag, input int d, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s variant=%0d actual=%0d expected=%0d", tag, d, act, exp);
        end
    endtask

    task automatic clear_stats();
        j = 0;
        for (int d = 0; d < 2; d++) begin
            n_ho[d] = 0; n_lo[d] = 0; first_ho[d] = 0; first_lo[d] = 0;
            last_ho[d] = 0; last_lo[d] = 0;
        end
    endtask

    task automatic step();
        @(negedge clk);
        j++;
        for (int d = 0; d < 2; d++) begin
            if (ho[d]) begin
                n_ho[d]++;
                if (first_ho[d] == 0) first_ho[d] = j;
                last_ho[d] = j;
            end
            if (lo[d]) begin
                n_lo[d]++;
                if (first_lo[d] == 0) first_lo[d] = j;
                last_lo[d] = j;
            end
        end
    endtask

    task automatic steps(input int n);
        for (int s = 0; s < n; s++) step();
    endtask

    task automatic set_side(input bit high, input logic v);
        if (high) hi = v; else li = v;
    endtask

    // R1 R2: single pulse of P samples on one side from a settled idle state
    task automatic pulse(input bit high, input int p);
        clear_stats();
        set_side(high, 1'b1);
        for (int s = 1; s <= 40; s++) begin
            step();
            if (j == p) set_side(high, 1'b0);
        end
        for (int d = 0; d < 2; d++) begin
            int w = wid(d);
            check(p >= w ? "R2 width" : "R1 reject", d,
                  high ? n_ho[d] : n_lo[d], p >= w ? p : 0);
            check("R2 delay", d, high ? first_ho[d] : first_lo[d], p >= w ? w + 1 : 0);
            check("R5 other side idle", d, high ? n_lo[d] : n_ho[d], 0);
        end
    endtask

    // R6 R7 R8: handover with the new command G samples after the old drops
    task automatic handover(input bit from_high, input int g);
        set_side(from_high, 1'b1);
        steps(30);
        clear_stats();
        set_side(from_high, 1'b0);
        if (g == 0) set_side(!from_high, 1'b1);
        for (int s = 1; s <= WIN; s++) begin
            step();
            if (j == g) set_side(!from_high, 1'b1);
        end
        for (int d = 0; d < 2; d++) begin
            int w = wid(d);
            check(from_high ? "R6 off edge" : "R7 off edge", d,
                  from_high ? last_ho[d] : last_lo[d], w);
            check(g > DT ? "R8 late command" : (from_high ? "R6 dead time" : "R7 dead time"), d,
                  (from_high ? first_lo[d] : first_ho[d]) - w - 1, imax(DT, g));
        end
        hi = 1'b0; li = 1'b0;
        steps(40);
    endtask

    // R4: low command overlaps a steady high command for L samples
    task automatic overlap(input int l);
        hi = 1'b1;
        steps(30);
        clear_stats();
        li = 1'b1;
        for (int s = 1; s <= WIN; s++) begin
            step();
            if (j == l) li = 1'b0;
        end
        for (int d = 0; d < 2; d++) begin
            int w = wid(d);
            check("R4 high off during clash", d, WIN - n_ho[d], l >= w ? l + DT - 1 : 0);
            check("R4 low stays off", d, n_lo[d], 0);
        end
        hi = 1'b0;
        steps(40);
    endtask

    // R9: high command returns for L samples M samples into the low side's countdown
    task automatic abandon(input int m, input int l);
        hi = 1'b1;
        steps(30);
        clear_stats();
        hi = 1'b0;
        li = 1'b1;
        for (int s = 1; s <= WIN; s++) begin
            step();
            if (j == m) hi = 1'b1;
            if (j == m + l) hi = 1'b0;
        end
        for (int d = 0; d < 2; d++) begin
            int w = wid(d);
            check("R9 restart", d, first_lo[d], m + l + w + DT);
            check("R9 high not re-enabled", d, n_ho[d], w);
        end
        li = 1'b0;
        steps(40);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset holds enables low even with a command present
        hi = 1'b1;
        repeat (5) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check("R10 reset high", d, int'(ho[d]), 0);
            check("R10 reset low", d, int'(lo[d]), 0);
        end
        clear_stats();
        rst_n = 1'b1;
        steps(30);
        for (int d = 0; d < 2; d++)
            check("R10 first turn-on waits gap", d, first_ho[d], DT);
        hi = 1'b0;
        steps(40);

        for (int p = 1; p <= 8; p++) begin
            pulse(1'b1, p);
            pulse(1'b0, p);
        end
        for (int g = 0; g <= 20; g++) begin
            handover(1'b1, g);
            handover(1'b0, g);
        end
        for (int l = 1; l <= 10; l++) overlap(l);
        for (int m = 4; m <= 10; m++) abandon(m, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule